// File: doc/BRIEF.md
# CAN Protocol Status Register Unit

This block gathers the status events that a CAN FD protocol engine reports and shows them to a host as one 32-bit read-only word. Some fields are live copies of engine state: the delay compensation value, the activity state, bus-off, and the warning and error-passive levels taken from the two error counters. The other fields are stored. There are two 3-bit error code fields, one for the arbitration and control part of a frame and one for the data phase of bit-rate-switched FD frames. There are also four flags: a protocol exception flag, a received-FD-frame flag, and the BRS and ESI values captured from the last received FD frame.

The host reads the word whenever it likes. `rd_data` always shows the value held at that moment. A pulse on `rd_strobe` marks a read, and the side effects of that read take place on the clock edge that ends the strobe cycle. Both error codes go back to 7, meaning no new event since the last read, and the four flags clear. If a new event arrives in the same cycle as a read, the event wins. A frame that completes without error sets the error codes to 0, as described in R6 and R7.

Top module: `can_psr_top`

## Requirements
- R1: After a synchronous active-low reset, with all engine inputs at 0, `rd_data` reads 0x00000707. Both error code fields hold 7 and every other field holds 0.
- R2: Live fields pass straight to `rd_data`: `tdc_value` at bits 22:16, `bus_off` at bit 7 and `activity` at bits 4:3. Activity uses 0 synchronizing, 1 idle, 2 receiver and 3 transmitter. Bits 31:23 and bit 15 always read 0.
- R3: Bit 6 (warning) is 1 when either `tx_err_cnt` or `rx_err_cnt` is at or above 96. Bit 5 (error-passive) is 1 when either counter is at or above 128. Reads change neither bit.
- R4: An error pulse with `err_data_phase`=0 loads `err_code` into bits 2:0 on the next cycle. Codes are 0 none, 1 stuff, 2 form, 3 ack, 4 bit1, 5 bit0, 6 CRC and 7 no change. A `recov_run11` pulse loads code 5 into bits 2:0, and a simultaneous error pulse takes precedence over it.
- R5: A `rd_strobe` cycle returns the value held before that cycle. On the following cycle both bits 2:0 and bits 10:8 read 7, unless the same cycle also carried an event for that field.
- R6: A `ok_valid` pulse for any frame sets bits 2:0 to 0 on the next cycle. An arbitration-phase error in the same cycle wins, and its code is loaded instead.
- R7: Bits 10:8 take a code only from an error pulse with `err_data_phase`=1. They clear to 0 only on a `ok_valid` pulse with both `ok_fd` and `ok_brs` set. A data-phase error never changes bits 2:0.
- R8: A `fdrx_valid` pulse sets bit 13, and in the same cycle loads bit 12 from `fdrx_brs` and bit 11 from `fdrx_esi`. A read clears all three bits.
- R9: A `pxe_pulse` sets bit 14, and a read clears it.
- R10: When a flag-setting event and a read fall in the same cycle, the flag reads as set afterwards. When an error code event and a read fall in the same cycle, the new code is held rather than 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_valid | input | 1 | Error event pulse |
| err_code | input | 3 | Code of the error event |
| err_data_phase | input | 1 | Error lies in the data phase of an FD frame with BRS set |
| recov_run11 | input | 1 | 11 recessive bits seen during bus-off recovery |
| ok_valid | input | 1 | Frame sent or received without error |
| ok_fd | input | 1 | That frame was FD format |
| ok_brs | input | 1 | That frame had BRS set |
| fdrx_valid | input | 1 | FD frame received (before acceptance filtering) |
| fdrx_brs | input | 1 | BRS bit of that frame |
| fdrx_esi | input | 1 | ESI bit of that frame |
| pxe_pulse | input | 1 | Protocol exception event |
| tx_err_cnt | input | CNT_W | Transmit error counter |
| rx_err_cnt | input | CNT_W | Receive error counter |
| bus_off | input | 1 | Engine is bus-off |
| activity | input | 2 | Engine activity state |
| tdc_value | input | 7 | Delay compensation value |
| rd_strobe | input | 1 | Host read of the status word |
| rd_data | output | 32 | Status word |

## Verification
The hardest cases to reach are the same-cycle collisions: a read landing together with an error, a flag event, or a clean transfer. In those cycles the priority between event, clear and read-reset decides the outcome. The bench raises the read strobe and the event in the same negative-edge drive window. Before the edge it checks that `rd_data` still shows the old value, and after the edge it checks that the event won. It also walks the data-phase field through an FD frame without BRS, where nothing may clear, and then through a frame with BRS, where it must clear.

// File: rtl/can_psr_pkg.sv
// Shared widths and error code values for the CAN protocol status unit.
package can_psr_pkg;
    localparam int CODE_W = 3;
    typedef logic [CODE_W-1:0] err_code_t;
    localparam err_code_t EC_NONE  = 3'd0;
    localparam err_code_t EC_BIT0  = 3'd5;
    localparam err_code_t EC_NOCHG = 3'd7;
endpackage

// File: rtl/can_psr_errcode.sv
// One stored error code field. Priority: load > clear > read reset to 7.
// Assumes load, clr and rd are single-cycle strobes in the core clock domain.
module can_psr_errcode
    import can_psr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  err_code_t load_code,
    input  logic      clr,
    input  logic      rd,
    output err_code_t q
);
    // Update the field with the stated priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= EC_NOCHG;
        else if (load)   q <= load_code;
        else if (clr)    q <= EC_NONE;
        else if (rd)     q <= EC_NOCHG;
    end

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(load_code));
    // R6
    clean_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !load) |=> q == EC_NONE);
    // R5
    read_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !load && !clr) |=> q == EC_NOCHG);
endmodule

// File: rtl/can_psr_flags.sv
// Clear-on-read event flags: protocol exception, FD received, and the
// BRS and ESI values captured from the last FD frame. A set beats a clear.
module can_psr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic pxe_set,
    input  logic fd_set,
    input  logic fd_brs,
    input  logic fd_esi,
    output logic pxe_q,
    output logic fd_q,
    output logic brs_q,
    output logic esi_q
);
    // Protocol exception flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       pxe_q <= 1'b0;
        else if (pxe_set) pxe_q <= 1'b1;
        else if (rd)      pxe_q <= 1'b0;
    end

    // FD-received flag and its captured BRS and ESI bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fd_q  <= 1'b0;
            brs_q <= 1'b0;
            esi_q <= 1'b0;
        end else if (fd_set) begin
            fd_q  <= 1'b1;
            brs_q <= fd_brs;
            esi_q <= fd_esi;
        end else if (rd) begin
            fd_q  <= 1'b0;
            brs_q <= 1'b0;
            esi_q <= 1'b0;
        end
    end

    // R9
    pxe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pxe_set |=> pxe_q);
    // R8
    fd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fd_set |=> fd_q && brs_q == $past(fd_brs) && esi_q == $past(fd_esi));
    // R8
    fd_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !fd_set) |=> !fd_q && !brs_q && !esi_q);
endmodule

// File: rtl/can_psr_live.sv
// Error-level decode from the two error counters. Purely combinational,
// so reads have no effect on it. Assumes the counters are stable in the core domain.
module can_psr_live #(
    parameter int CNT_W      = 9,
    parameter int WARN_LIM   = 96,
    parameter int PASSIVE_LIM = 128
) (
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    output logic             warn,
    output logic             passive
);
    localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASSIVE_LIM);

    // Compare each counter against the limits.
    always_comb begin
        warn    = (tx_cnt >= WARN_V) || (rx_cnt >= WARN_V);
        passive = (tx_cnt >= PASS_V) || (rx_cnt >= PASS_V);
    end
endmodule

// File: rtl/can_psr_top.sv
// CAN protocol status word. Routes engine events to the stored fields and
// assembles the 32-bit read word. rd_data shows the held state; the side
// effects of a read take place on the edge that ends the rd_strobe cycle.
module can_psr_top
    import can_psr_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_valid,
    input  logic [2:0]       err_code,
    input  logic             err_data_phase,
    input  logic             recov_run11,
    input  logic             ok_valid,
    input  logic             ok_fd,
    input  logic             ok_brs,
    input  logic             fdrx_valid,
    input  logic             fdrx_brs,
    input  logic             fdrx_esi,
    input  logic             pxe_pulse,
    input  logic [CNT_W-1:0] tx_err_cnt,
    input  logic [CNT_W-1:0] rx_err_cnt,
    input  logic             bus_off,
    input  logic [1:0]       activity,
    input  logic [6:0]       tdc_value,
    input  logic             rd_strobe,
    output logic [31:0]      rd_data
);
    logic      lec_load, dlec_load, dlec_clr;
    err_code_t lec_code, lec_q, dlec_q;
    logic      pxe_q, fd_q, brs_q, esi_q, warn, passive;

    // Route errors by phase; a recovery run writes bit0 unless an error coincides.
    always_comb begin
        lec_load  = (err_valid && !err_data_phase) || recov_run11;
        lec_code  = (err_valid && !err_data_phase) ? err_code : EC_BIT0;
        dlec_load = err_valid && err_data_phase;
        dlec_clr  = ok_valid && ok_fd && ok_brs;
    end

    can_psr_errcode u_lec (
        .clk(clk), .rst_n(rst_n), .load(lec_load), .load_code(lec_code),
        .clr(ok_valid), .rd(rd_strobe), .q(lec_q)
    );

    can_psr_errcode u_dlec (
        .clk(clk), .rst_n(rst_n), .load(dlec_load), .load_code(err_code),
        .clr(dlec_clr), .rd(rd_strobe), .q(dlec_q)
    );

    can_psr_flags u_flags (
        .clk(clk), .rst_n(rst_n), .rd(rd_strobe), .pxe_set(pxe_pulse),
        .fd_set(fdrx_valid), .fd_brs(fdrx_brs), .fd_esi(fdrx_esi),
        .pxe_q(pxe_q), .fd_q(fd_q), .brs_q(brs_q), .esi_q(esi_q)
    );

    can_psr_live #(.CNT_W(CNT_W)) u_live (
        .tx_cnt(tx_err_cnt), .rx_cnt(rx_err_cnt), .warn(warn), .passive(passive)
    );

    // Assemble the status word.
    always_comb begin
        rd_data = {9'd0, tdc_value, 1'b0, pxe_q, fd_q, brs_q, esi_q, dlec_q,
                   bus_off, warn, passive, activity, lec_q};
    end

    // R7
    dlec_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_data_phase && !recov_run11 && !ok_valid && !rd_strobe)
        |=> $stable(lec_q));
    // R4
    recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (recov_run11 && !err_valid) |=> lec_q == EC_BIT0);
endmodule

// File: tb/can_psr_top_tb.sv
module can_psr_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_valid = 0, err_data_phase = 0, recov_run11 = 0;
    logic [2:0] err_code = 0;
    logic ok_valid = 0, ok_fd = 0, ok_brs = 0;
    logic fdrx_valid = 0, fdrx_brs = 0, fdrx_esi = 0, pxe_pulse = 0;
    logic [8:0] tx_err_cnt = 0, rx_err_cnt = 0;
    logic bus_off = 0;
    logic [1:0] activity = 0;
    logic [6:0] tdc_value = 0;
    logic rd_strobe = 0;
    logic [31:0] rd_data;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    can_psr_top u_dut (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_code(err_code),
        .err_data_phase(err_data_phase), .recov_run11(recov_run11),
        .ok_valid(ok_valid), .ok_fd(ok_fd), .ok_brs(ok_brs),
        .fdrx_valid(fdrx_valid), .fdrx_brs(fdrx_brs), .fdrx_esi(fdrx_esi),
        .pxe_pulse(pxe_pulse), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .bus_off(bus_off), .activity(activity), .tdc_value(tdc_value),
        .rd_strobe(rd_strobe), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Let one edge pass, then drop all event strobes.
    task automatic step();
        @(negedge clk);
        err_valid = 0; recov_run11 = 0; ok_valid = 0; fdrx_valid = 0;
        pxe_pulse = 0; rd_strobe = 0;
    endtask

    function automatic logic [2:0] lec(); return rd_data[2:0]; endfunction
    function automatic logic [2:0] dlec(); return rd_data[10:8]; endfunction

    task automatic t_reset();
        check("R1 reset word", rd_data, 32'h0000_0707);
    endtask

    task automatic t_live();
        tdc_value = 7'h55; activity = 2'd2; bus_off = 1; #1;
        check("R2 tdc field", {25'd0, rd_data[22:16]}, 32'h55);
        check("R2 activity receiver", {30'd0, rd_data[4:3]}, 2);
        check("R2 bus-off bit", {31'd0, rd_data[7]}, 1);
        check("R2 reserved zero", {23'd0, rd_data[31:23]} | {31'd0, rd_data[15]}, 0);
        tdc_value = 0; activity = 2'd1; bus_off = 0; #1;
        check("R2 activity idle", {30'd0, rd_data[4:3]}, 1);
    endtask

    task automatic t_counters();
        tx_err_cnt = 95; #1;
        check("R3 warn at 95", {31'd0, rd_data[6]}, 0);
        tx_err_cnt = 96; #1;
        check("R3 warn at 96", {31'd0, rd_data[6]}, 1);
        check("R3 passive at 96", {31'd0, rd_data[5]}, 0);
        tx_err_cnt = 0; rx_err_cnt = 128; #1;
        check("R3 rx passive at 128", {30'd0, rd_data[6:5]}, 3);
        rd_strobe = 1; step();
        check("R3 read leaves passive", {30'd0, rd_data[6:5]}, 3);
        rx_err_cnt = 127; #1;
        check("R3 passive at 127", {30'd0, rd_data[6:5]}, 2);
        rx_err_cnt = 0; #1;
    endtask

    task automatic t_lec();
        err_valid = 1; err_code = 3; err_data_phase = 0; step();
        check("R4 ack code", {29'd0, lec()}, 3);
        check("R7 dlec untouched", {29'd0, dlec()}, 7);
        recov_run11 = 1; step();
        check("R4 recovery bit0", {29'd0, lec()}, 5);
        recov_run11 = 1; err_valid = 1; err_code = 6; step();
        check("R4 error beats recovery", {29'd0, lec()}, 6);
    endtask

    task automatic t_read();
        rd_strobe = 1; #1;
        check("R5 read returns old", {29'd0, lec()}, 6);
        step();
        check("R5 lec to 7", {29'd0, lec()}, 7);
        check("R5 dlec to 7", {29'd0, dlec()}, 7);
    endtask

    task automatic t_clean();
        ok_valid = 1; ok_fd = 0; ok_brs = 0; step();
        check("R6 clean clears lec", {29'd0, lec()}, 0);
        check("R7 classic frame keeps dlec", {29'd0, dlec()}, 7);
        ok_valid = 1; err_valid = 1; err_code = 2; err_data_phase = 0; step();
        check("R6 error beats clean", {29'd0, lec()}, 2);
    endtask

    task automatic t_dlec();
        err_valid = 1; err_code = 6; err_data_phase = 1; step();
        err_data_phase = 0;
        check("R7 data phase code", {29'd0, dlec()}, 6);
        check("R7 lec unchanged", {29'd0, lec()}, 2);
        ok_valid = 1; ok_fd = 1; ok_brs = 0; step();
        check("R7 no-brs keeps dlec", {29'd0, dlec()}, 6);
        check("R6 fd frame clears lec", {29'd0, lec()}, 0);
        ok_valid = 1; ok_fd = 1; ok_brs = 1; step();
        ok_fd = 0; ok_brs = 0;
        check("R7 brs frame clears dlec", {29'd0, dlec()}, 0);
    endtask

    task automatic t_flags();
        fdrx_valid = 1; fdrx_brs = 1; fdrx_esi = 0; step();
        check("R8 fd brs esi", {29'd0, rd_data[13:11]}, 3'b110);
        fdrx_valid = 1; fdrx_brs = 0; fdrx_esi = 1; step();
        check("R8 recapture", {29'd0, rd_data[13:11]}, 3'b101);
        rd_strobe = 1; step();
        check("R8 read clears", {29'd0, rd_data[13:11]}, 0);
        pxe_pulse = 1; step();
        check("R9 pxe set", {31'd0, rd_data[14]}, 1);
        rd_strobe = 1; step();
        check("R9 pxe cleared", {31'd0, rd_data[14]}, 0);
    endtask

    task automatic t_collide();
        rd_strobe = 1; err_valid = 1; err_code = 1; err_data_phase = 0; #1;
        check("R10 read sees old lec", {29'd0, lec()}, 7);
        step();
        check("R10 error beats read", {29'd0, lec()}, 1);
        check("R10 other field reset", {29'd0, dlec()}, 7);
        rd_strobe = 1; pxe_pulse = 1; fdrx_valid = 1; fdrx_brs = 0; fdrx_esi = 1; #1;
        check("R10 read sees old flags", {28'd0, rd_data[14:11]}, 0);
        step();
        check("R10 flags beat read", {28'd0, rd_data[14:11]}, 4'b1101);
        rd_strobe = 1; err_valid = 1; err_code = 4; err_data_phase = 1; step();
        err_data_phase = 0;
        check("R10 dlec beats read", {29'd0, dlec()}, 4);
        check("R10 lec read reset", {29'd0, lec()}, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_live();
        t_counters();
        t_lec();
        t_read();
        t_clean();
        t_dlec();
        t_flags();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule